// File: doc/BRIEF.md
# Serial LED Sink Driver Core

This block is the synchronous digital heart of a sixteen-channel constant-current LED sink driver. Serial display data enters on `sdi_i` and moves one place on each rising edge of `clk_i`. The oldest bit leaves on `sdo_o`, so several drivers can be chained. A level-sensitive latch stages the shift contents. An active-low enable then gates the latched word onto the per-channel on controls. The analog current regulators sit outside this block and obey those controls.

A fault-check session is started with a five-clock pattern on the enable and latch pins. The host first latches an all-ones word. It then holds the enable low long enough for the outside comparators to settle (at least 1 us). While the enable is low, the block samples two digital fault inputs per channel: open-or-grounded, and shorted-LED-or-supply. When the enable goes back high, the block loads one flag per channel into the shift chain. The host clocks the flags out in the same order as display data. A second five-clock pattern returns the core to normal operation.

The core also raises a power-save indication. It does so when the latched word holds no active bit and has stayed the same for a set number of clocks. It drops the indication as soon as a word with any active bit is latched.

Top module: `led_sink_core`

## Requirements
- R1: On each rising clock edge the chain takes `sdi_i` into bit 0 and moves every bit one place up, except on a fault-load edge. `sdo_o` always shows bit 15. The first of sixteen shifted bits therefore ends up at channel 15 and the last at channel 0.
- R2: While `le_i` is high, the latch output follows the chain contents, including the value the chain takes at a clock edge during which `le_i` is high. While `le_i` is low, the latch holds its value.
- R3: While `oe_n_i` is low, `chan_on_o[k]` equals latched bit k. While `oe_n_i` is high, all sixteen bits of `chan_on_o` are 0.
- R4: In normal mode, five consecutive clock samples of (`oe_n_i`, `le_i`) equal to (1,0), (0,0), (1,0), (1,1), (1,0) switch the core into detect mode. In detect mode, the first clock edge that sees `oe_n_i` high right after it was low replaces the chain with the fault flags, with channel k's flag in bit k. Channel 15's flag therefore appears first on `sdo_o`.
- R5: A channel's flag is 1 when its open input or its short input (or both) was active at the last clock edge with `oe_n_i` low in detect mode. It is 0 otherwise. Fault inputs seen at other times have no effect.
- R6: Only one fault load happens per detect session. Later low-to-high enable transitions shift normally.
- R7: In detect mode, five samples (1,0), (0,0), (1,0), (1,0), (1,0) return the core to normal mode. In normal mode, no enable transition loads flags. A new session is possible after a return to normal mode.
- R8: `pwr_save_o` is 1 only when the latch output is all zeros and the latched value has not changed for IDLE_CYC (default 16) clock edges. It goes to 0 in the same cycle that a nonzero word is latched.
- R9: An asynchronous active-low reset clears the chain and the latch and selects normal mode. It also leaves `pwr_save_o` at 1, with all outputs off and `sdo_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| sdi_i | input | 1 | Serial data in |
| le_i | input | 1 | Latch transparency control, active high |
| oe_n_i | input | 1 | Output enable, active low |
| fault_open_i | input | CHANNELS | Per-channel open-line or short-to-ground flags |
| fault_short_i | input | CHANNELS | Per-channel shorted-LED or short-to-supply flags |
| sdo_o | output | 1 | Serial data out, bit 15 of the chain |
| chan_on_o | output | CHANNELS | Per-channel current sink on controls |
| pwr_save_o | output | 1 | Power-save indication |

## Verification
Assertions check some properties on every clock edge. The serial output follows the chain one bit per clock, a fault load copies the fault register exactly, and mode changes only on a (1,0) sample. The latch never moves while `le_i` is low. Power-save only rises with the latch steady, and no channel is ever on while the enable is high or power-save is asserted. Other behaviours need the bench's scenarios to show. These include the exact five-step entry and exit patterns, the readback order of flags built from both fault classes, and the one-load-per-session rule. So do the exact clock on which power-save appears after a zero word and the fact that entry works again after an exit.

// File: rtl/led_core_pkg.sv
package led_core_pkg;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_DETECT = 1'b1
    } drv_mode_e;

    // Pin-pattern history, bit 3 oldest, bit 0 newest; the fifth sample is
    // the current one and must be (oe_n=1, le=0) for both patterns.
    localparam int          HIST_LEN       = 4;
    localparam logic [3:0]  OE_PAT_HIST    = 4'b1011;
    localparam logic [3:0]  LE_ENTER_HIST  = 4'b0001;
    localparam logic [3:0]  LE_LEAVE_HIST  = 4'b0000;

endpackage

// File: rtl/led_shift_chain.sv
module led_shift_chain #(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             sdi_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic [WIDTH-1:0] chain_o,
    output logic [WIDTH-1:0] chain_nxt_o,
    output logic             sdo_o
);

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (load_i) begin
            chain_d.bits = load_val_i;
        end else begin
            chain_d.bits = {chain_q.bits[WIDTH-2:0], sdi_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign chain_o     = chain_q.bits;
    assign chain_nxt_o = chain_d.bits;
    assign sdo_o       = chain_q.bits[WIDTH-1];

    // R1
    sdo_follows_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !load_i |=> sdo_o == $past(chain_q.bits[WIDTH-2]));

    // R4
    load_copies_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        load_i |=> chain_o == $past(load_val_i));

endmodule

// File: rtl/led_mode_ctrl.sv
module led_mode_ctrl
    import led_core_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             oe_n_i,
    input  logic             le_i,
    input  logic [WIDTH-1:0] fault_open_i,
    input  logic [WIDTH-1:0] fault_short_i,
    output logic             load_o,
    output logic [WIDTH-1:0] load_val_o
);

    typedef struct packed {
        drv_mode_e              mode;
        logic                   captured;
        logic                   oe_prev;
        logic [HIST_LEN-1:0]    hist_oe;
        logic [HIST_LEN-1:0]    hist_le;
        logic [WIDTH-1:0]       flags;
    } mode_state_t;

    mode_state_t st_d, st_q;
    logic        pat_tail;
    logic        enter_hit;
    logic        leave_hit;
    logic        load_hit;

    always_comb begin
        st_d      = st_q;
        pat_tail  = oe_n_i && !le_i && (st_q.hist_oe == OE_PAT_HIST);
        enter_hit = pat_tail && (st_q.hist_le == LE_ENTER_HIST)
                    && (st_q.mode == MODE_NORMAL);
        leave_hit = pat_tail && (st_q.hist_le == LE_LEAVE_HIST)
                    && (st_q.mode == MODE_DETECT);
        load_hit  = (st_q.mode == MODE_DETECT) && !st_q.captured
                    && !st_q.oe_prev && oe_n_i;

        st_d.oe_prev = oe_n_i;
        st_d.hist_oe = {st_q.hist_oe[HIST_LEN-2:0], oe_n_i};
        st_d.hist_le = {st_q.hist_le[HIST_LEN-2:0], le_i};

        if ((st_q.mode == MODE_DETECT) && !oe_n_i) begin
            st_d.flags = fault_open_i | fault_short_i;
        end
        if (load_hit) begin
            st_d.captured = 1'b1;
        end

        if (enter_hit) begin
            st_d.mode     = MODE_DETECT;
            st_d.captured = 1'b0;
            st_d.flags    = '0;
            st_d.hist_oe  = '0;
            st_d.hist_le  = '0;
        end else if (leave_hit) begin
            st_d.mode     = MODE_NORMAL;
            st_d.hist_oe  = '0;
            st_d.hist_le  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q <= '{mode: MODE_NORMAL, captured: 1'b0, oe_prev: 1'b0,
                      hist_oe: '0, hist_le: '0, flags: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o     = load_hit;
    assign load_val_o = st_q.flags;

    // R7
    mode_change_on_idle_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !$stable(st_q.mode) |-> $past(oe_n_i) && !$past(le_i));

    // R6
    single_load_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        load_o |=> !load_o && st_q.captured);

endmodule

// File: rtl/led_latch_stage.sv
module led_latch_stage #(
    parameter int WIDTH    = 16,
    parameter int IDLE_CYC = 16
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             le_i,
    input  logic [WIDTH-1:0] chain_i,
    input  logic [WIDTH-1:0] chain_nxt_i,
    output logic [WIDTH-1:0] latched_o,
    output logic             pwr_save_o
);

    localparam int CNT_W = $clog2(IDLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(IDLE_CYC);

    typedef struct packed {
        logic [WIDTH-1:0] hold;
        logic [CNT_W-1:0] idle;
    } latch_state_t;

    latch_state_t lt_d, lt_q;
    logic [WIDTH-1:0] view;

    always_comb begin
        lt_d = lt_q;
        if (le_i) begin
            lt_d.hold = chain_nxt_i;
        end
        if (lt_d.hold != lt_q.hold) begin
            lt_d.idle = '0;
        end else if (lt_q.idle != CNT_FULL) begin
            lt_d.idle = lt_q.idle + 1'b1;
        end
        view = le_i ? chain_i : lt_q.hold;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            lt_q <= '{hold: '0, idle: CNT_FULL};
        end else begin
            lt_q <= lt_d;
        end
    end

    assign latched_o  = view;
    assign pwr_save_o = (view == '0) && (lt_q.idle == CNT_FULL);

    // R2
    hold_when_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !le_i |=> lt_q.hold == $past(lt_q.hold));

    // R8
    save_needs_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(pwr_save_o) |-> lt_q.hold == $past(lt_q.hold));

endmodule

// File: rtl/led_sink_core.sv
module led_sink_core
    import led_core_pkg::*;
#(
    parameter int CHANNELS = 16,
    parameter int IDLE_CYC = 16
) (
    input  logic                clk_i,
    input  logic                rst_n_i,
    input  logic                sdi_i,
    input  logic                le_i,
    input  logic                oe_n_i,
    input  logic [CHANNELS-1:0] fault_open_i,
    input  logic [CHANNELS-1:0] fault_short_i,
    output logic                sdo_o,
    output logic [CHANNELS-1:0] chan_on_o,
    output logic                pwr_save_o
);

    logic                load;
    logic [CHANNELS-1:0] load_val;
    logic [CHANNELS-1:0] chain;
    logic [CHANNELS-1:0] chain_nxt;
    logic [CHANNELS-1:0] latched;

    led_mode_ctrl #(.WIDTH(CHANNELS)) mode_i (
        .clk_i         (clk_i),
        .rst_n_i       (rst_n_i),
        .oe_n_i        (oe_n_i),
        .le_i          (le_i),
        .fault_open_i  (fault_open_i),
        .fault_short_i (fault_short_i),
        .load_o        (load),
        .load_val_o    (load_val)
    );

    led_shift_chain #(.WIDTH(CHANNELS)) chain_i (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .sdi_i       (sdi_i),
        .load_i      (load),
        .load_val_i  (load_val),
        .chain_o     (chain),
        .chain_nxt_o (chain_nxt),
        .sdo_o       (sdo_o)
    );

    led_latch_stage #(.WIDTH(CHANNELS), .IDLE_CYC(IDLE_CYC)) latch_i (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .le_i        (le_i),
        .chain_i     (chain),
        .chain_nxt_i (chain_nxt),
        .latched_o   (latched),
        .pwr_save_o  (pwr_save_o)
    );

    for (genvar k = 0; k < CHANNELS; k++) begin : g_gate
        assign chan_on_o[k] = latched[k] & ~oe_n_i;
    end

    // R3
    no_drive_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (chan_on_o != '0) |-> !oe_n_i && !pwr_save_o);

endmodule

// File: tb/led_sink_core_tb_top.sv
`timescale 1ns/1ps
module led_sink_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sdi;
    logic        le;
    logic        oe_n;
    logic [15:0] f_open;
    logic [15:0] f_short;
    logic        sdo;
    logic [15:0] chan_on;
    logic        pwr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [15:0] PATS [5] = '{16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF, 16'h3C5A};

    always #10 clk = ~clk;

    led_sink_core dut_i (
        .clk_i         (clk),
        .rst_n_i       (rst_n),
        .sdi_i         (sdi),
        .le_i          (le),
        .oe_n_i        (oe_n),
        .fault_open_i  (f_open),
        .fault_short_i (f_short),
        .sdo_o         (sdo),
        .chan_on_o     (chan_on),
        .pwr_save_o    (pwr)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic l, input logic o);
        sdi = s; le = l; oe_n = o;
        @(posedge clk);
        @(negedge clk);
    endtask

    // shift a word so its bit 15 enters first; latch on the last edge if asked
    task automatic load_word(input logic [15:0] w, input logic o, input logic do_latch);
        for (int i = 15; i >= 0; i--) step(w[i], (i == 0) && do_latch, o);
    endtask

    task automatic enter_detect();
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] flags;
        rst_n = 1'b0; sdi = 1'b0; le = 1'b0; oe_n = 1'b0;
        f_open = '0; f_short = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 chan_on in reset", chan_on, 16'h0);
        chk("R9 sdo in reset", {15'b0, sdo}, 16'h0);
        chk("R9 pwr_save in reset", {15'b0, pwr}, 16'h1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 table walk
        for (int p = 0; p < 5; p++) begin
            load_word(PATS[p], 1'b0, 1'b1);
            chk("R1 channel order", chan_on, PATS[p]);
            chk("R1 sdo shows bit 15", {15'b0, sdo}, {15'b0, PATS[p][15]});
            chk("R8 released on nonzero latch", {15'b0, pwr}, 16'h0);
            step(1'b0, 1'b0, 1'b1);
            chk("R3 outputs off while disabled", chan_on, 16'h0);
            chk("R7 normal mode enable rise shifts", {15'b0, sdo}, {15'b0, PATS[p][14]});
            oe_n = 1'b0; #2;
            chk("R2 latch holds while closed", chan_on, PATS[p]);
            @(negedge clk);
        end

        // R2 transparency without an edge
        load_word(16'h0F0F, 1'b0, 1'b0);
        chk("R2 hold during shifting", chan_on, PATS[4]);
        le = 1'b1; #2;
        chk("R2 transparent while open", chan_on, 16'h0F0F);
        le = 1'b0; #2;
        chk("R2 closed again without edge", chan_on, PATS[4]);
        @(negedge clk);

        // R8 power-save timing
        load_word(16'h0000, 1'b0, 1'b1);
        chk("R8 zero just latched", {15'b0, pwr}, 16'h0);
        repeat (15) step(1'b0, 1'b0, 1'b0);
        chk("R8 one edge before idle limit", {15'b0, pwr}, 16'h0);
        step(1'b0, 1'b0, 1'b0);
        chk("R8 asserted at idle limit", {15'b0, pwr}, 16'h1);
        load_word(16'h0010, 1'b0, 1'b1);
        chk("R8 released same cycle", {15'b0, pwr}, 16'h0);
        chk("R3 single channel on", chan_on, 16'h0010);

        // R4 R5 detection session
        load_word(16'hFFFF, 1'b1, 1'b1);
        enter_detect();
        f_open  = 16'h0181;
        f_short = 16'h1300;
        flags   = f_open | f_short;
        repeat (60) step(1'b0, 1'b0, 1'b0);
        chk("R4 all channels conduct in window", chan_on, 16'hFFFF);
        f_open = '0; f_short = '0;
        step(1'b0, 1'b0, 1'b1);
        chk("R4 first flag is channel 15", {15'b0, sdo}, {15'b0, flags[15]});
        for (int n = 1; n < 16; n++) begin
            step(1'b0, 1'b0, 1'b1);
            chk("R5 flag readback order", {15'b0, sdo}, {15'b0, flags[15-n]});
        end
        step(1'b0, 1'b0, 1'b1);
        chk("R1 chain drained", {15'b0, sdo}, 16'h0);

        // R6 no second load in the same session
        f_open = 16'hFFFF;
        repeat (3) step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        chk("R6 no reload in session", {15'b0, sdo}, 16'h0);

        // R7 leave detect mode, then no load
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        repeat (2) step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        chk("R7 no load in normal mode", {15'b0, sdo}, 16'h0);

        // R7 new session after leaving
        f_open = '0;
        enter_detect();
        f_open = 16'h8000; f_short = 16'h0001;
        repeat (55) step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        chk("R7 second session loads channel 15", {15'b0, sdo}, 16'h1);
        repeat (15) step(1'b0, 1'b0, 1'b1);
        chk("R5 short-only channel 0 flag", {15'b0, sdo}, 16'h1);

        // R9 reset mid-run
        oe_n = 1'b0;
        rst_n = 1'b0; #2;
        chk("R9 chan_on after reset", chan_on, 16'h0);
        chk("R9 pwr_save after reset", {15'b0, pwr}, 16'h1);
        chk("R9 sdo after reset", {15'b0, sdo}, 16'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule